// File: doc/BRIEF.md
# Static Memory Cycle Controller

This block sequences the control strobes for up to six external static-memory segments. A requester presents one access at a time on a valid/ready request channel: a segment index, an in-segment address and a read/write flag. The controller drives the active-low select of the chosen segment, the shared active-low output-enable and write-enable strobes, and an external ready input that can stretch the final wait cycle. A one-cycle `done` pulse marks the cycle in which each access completes. The data path, byte-lane steering and address-to-segment decoding are handled by neighbouring logic.

Each segment has static configuration inputs: data width, a random-access wait count, a sequential wait count, a page-mode enable, and a flag saying the device is writable through the write strobe. Back-to-back accesses to one segment keep its select low. After four accesses in a row the select is dropped for one cycle, so other bus masters such as DMA or refresh can get onto the bus. Segment 0 is the boot segment. Its width does not come from the configuration inputs: it is taken from two strap pins as power-on reset ends.

Back-pressure rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is running and the bus is not in its forced-release cycle. While `req_valid` is high and `req_ready` is low, the requester holds every request field stable. `req_seg` must be below the segment count.

Top module: `smc_ctrl`

## Requirements
- R1: While `por_n` is low and in the first cycle after it rises, every `cs_n` bit, `oe_n` and `we_n` are high, `req_ready` is high and `done` is low.
- R2: A random access with random field r (0 to 7, meaning r+1 wait states) keeps the segment's `cs_n` low for r+2 cycles, counted from the first selected cycle up to and including the `done` cycle. Throughout those cycles `oe_n` is low for a read and `we_n` is low for a write, and the two strobes are never low together.
- R3: An access is sequential when four things hold: it is accepted while the same segment's select is still held from the previous access, that segment's page-mode bit is set, and its address equals the previous address plus the access size. The access size follows the width code: 00 is 4 bytes, 01 is 1 byte, 10 is 2 bytes, and 11 is treated as 4 bytes. A sequential access with sequential field s (0 to 3) lasts s+1 cycles. Any other access uses random timing.
- R4: With page mode off, every access uses random timing. For back-to-back accesses the select stays low between them, while the strobes go high for one cycle.
- R5: After the fourth consecutive access under one held select, all `cs_n` bits go high and `req_ready` is low for one cycle. The next access uses random timing.
- R6: On a segment whose writable flag is set, a sequential access with sequential field 0 takes one wait state, so it lasts 2 cycles.
- R7: `ext_ready` is sampled only in the last cycle of an access. Each cycle it is low there adds one cycle. A low level in earlier wait cycles has no effect.
- R8: The two strap pins are captured in the last clock cycle of power-on reset and ignored afterwards. 00 gives a 32-bit boot segment, 01 gives 8-bit, 10 gives 16-bit, and 11 gives 32-bit with `boot_undef` set. `boot_undef` stays constant until the next reset.
- R9: A request to a different segment, accepted while a select is held, moves the select straight to the new segment with no release cycle. It uses random timing and restarts the four-access count.
- R10: If no request is pending in the cycle after an access completes, the select is released one cycle later, and the next access is random.
- R11: `req_ready` is low in the cycle after every accepted request and stays low until the access completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| boot_strap | input | 2 | Boot width strap pins |
| boot_undef | output | 1 | Strap value 11 was latched |
| cfg_width | input | (NUM_SEG-1)*2 | Width codes for segments 1 and up, two bits per segment |
| cfg_rand_ws | input | NUM_SEG*RAND_W | Random wait field per segment (value+1 wait states) |
| cfg_seq_ws | input | NUM_SEG*SEQ_W | Sequential wait field per segment |
| cfg_page_en | input | NUM_SEG | Page-mode enable per segment |
| cfg_we_dev | input | NUM_SEG | Device is written through `we_n` |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_seg | input | SEG_W | Target segment index |
| req_addr | input | ADDR_W | Address within the segment |
| req_write | input | 1 | 1 for a write, 0 for a read |
| done | output | 1 | Access completes at the next rising edge |
| ext_ready | input | 1 | External cycle stretch, low to extend |
| cs_n | output | NUM_SEG | Segment selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
A corrupted wait counter or timing selection shows up within a single access: `done` arrives a cycle early or late relative to the first selected cycle, so every directed access measures that interval exactly. A wrong burst count or held-segment record only surfaces at the fourth access of a chain. There, the one-cycle release is missing or appears too early, or the following access takes sequential rather than random time, so chains of five accesses are driven in each timing mode. A wrong strap capture is invisible until the boot segment sees a sequential access, which then reveals the latched access size through its length.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_HOLD,
    ST_GAP
  } smc_state_e;

  localparam logic [1:0] WCODE_32 = 2'b00;
  localparam logic [1:0] WCODE_8  = 2'b01;
  localparam logic [1:0] WCODE_16 = 2'b10;

  // Byte count stepped by one access of the given width code.
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      WCODE_8:  width_bytes = 3'd1;
      WCODE_16: width_bytes = 3'd2;
      default:  width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/smc_boot_strap.sv
module smc_boot_strap
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] strap,
  output logic [1:0] boot_width,
  output logic       boot_undef
);

  logic [1:0] strap_q;

  // Tracks the pins while reset is held; the value of the final reset
  // cycle is what remains once por_n rises.
  always_ff @(posedge clk) begin
    if (!por_n) strap_q <= strap;
  end

  assign boot_undef = (strap_q == 2'b11);
  assign boot_width = boot_undef ? WCODE_32 : strap_q;

  assert_boot_stable_R8: assert property (@(posedge clk) disable iff (!por_n)
    por_n |=> $stable(boot_undef));

endmodule

// File: rtl/smc_seq_detect.sv
module smc_seq_detect
  import smc_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int SEG_W  = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              commit,
  input  logic              hold_active,
  input  logic [SEG_W-1:0]  cur_seg,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        width_code,
  output logic              is_seq
);

  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (!por_n)      last_addr <= '0;
    else if (commit) last_addr <= req_addr;
  end

  assign next_addr = last_addr + ADDR_W'(width_bytes(width_code));
  assign is_seq    = hold_active && (req_seg == cur_seg) && (req_addr == next_addr);

endmodule

// File: rtl/smc_wait_timer.sv
module smc_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  input  logic             ext_ready,
  output logic             fin
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!por_n)                     cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (active && cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  // Ready only matters once the programmed waits have run out.
  assign fin = active && (cnt == '0) && ext_ready;

  assert_wait_not_skipped_R7: assert property (@(posedge clk) disable iff (!por_n)
    (load && load_val != '0) |=> !fin);

endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int NUM_SEG   = 6,
  parameter int ADDR_W    = 28,
  parameter int RAND_W    = 3,
  parameter int SEQ_W     = 2,
  parameter int BURST_MAX = 4,
  localparam int SEG_W    = $clog2(NUM_SEG)
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic [1:0]                  boot_strap,
  output logic                        boot_undef,
  input  logic [(NUM_SEG-1)*2-1:0]    cfg_width,
  input  logic [NUM_SEG*RAND_W-1:0]   cfg_rand_ws,
  input  logic [NUM_SEG*SEQ_W-1:0]    cfg_seq_ws,
  input  logic [NUM_SEG-1:0]          cfg_page_en,
  input  logic [NUM_SEG-1:0]          cfg_we_dev,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [SEG_W-1:0]            req_seg,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_write,
  output logic                        done,
  input  logic                        ext_ready,
  output logic [NUM_SEG-1:0]          cs_n,
  output logic                        oe_n,
  output logic                        we_n
);

  localparam int CNT_W = RAND_W + 1;
  localparam int BC_W  = $clog2(BURST_MAX + 1);

  smc_state_e        state;
  logic [SEG_W-1:0]  cur_seg;
  logic              cur_wr;
  logic [BC_W-1:0]   burst;
  logic [1:0]        boot_width;
  logic [1:0]        seg_width [NUM_SEG];
  logic              accept;
  logic              is_seq;
  logic              use_seq;
  logic              fin;
  logic              sel_on;
  logic [SEQ_W-1:0]  seq_raw;
  logic [SEQ_W-1:0]  seq_eff;
  logic [CNT_W-1:0]  rand_wait;
  logic [CNT_W-1:0]  wait_val;

  smc_boot_strap u_strap (
    .clk        (clk),
    .por_n      (por_n),
    .strap      (boot_strap),
    .boot_width (boot_width),
    .boot_undef (boot_undef)
  );

  // Segment 0 takes its width from the straps, the rest from configuration.
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_width
    if (g == 0) begin : g_boot
      assign seg_width[g] = boot_width;
    end else begin : g_cfg
      assign seg_width[g] = cfg_width[(g-1)*2 +: 2];
    end
  end

  assign req_ready = (state == ST_IDLE) || (state == ST_HOLD);
  assign accept    = req_valid && req_ready;

  smc_seq_detect #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_seq (
    .clk         (clk),
    .por_n       (por_n),
    .commit      (accept),
    .hold_active (state == ST_HOLD),
    .cur_seg     (cur_seg),
    .req_seg     (req_seg),
    .req_addr    (req_addr),
    .width_code  (seg_width[req_seg]),
    .is_seq      (is_seq)
  );

  // Wait-state selection for the incoming request.
  always_comb begin
    use_seq   = is_seq && cfg_page_en[req_seg];
    seq_raw   = cfg_seq_ws[req_seg*SEQ_W +: SEQ_W];
    seq_eff   = (cfg_we_dev[req_seg] && seq_raw == '0) ? SEQ_W'(1) : seq_raw;
    rand_wait = CNT_W'(cfg_rand_ws[req_seg*RAND_W +: RAND_W]) + CNT_W'(1);
    wait_val  = use_seq ? CNT_W'(seq_eff) : rand_wait;
  end

  smc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .por_n     (por_n),
    .load      (accept),
    .load_val  (wait_val),
    .active    (state == ST_BUSY),
    .ext_ready (ext_ready),
    .fin       (fin)
  );

  always_ff @(posedge clk) begin
    if (!por_n) begin
      state   <= ST_IDLE;
      cur_seg <= '0;
      cur_wr  <= 1'b0;
      burst   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_BUSY;
          cur_seg <= req_seg;
          cur_wr  <= req_write;
          burst   <= BC_W'(1);
        end
        ST_BUSY: if (fin) begin
          state <= (burst == BC_W'(BURST_MAX)) ? ST_GAP : ST_HOLD;
        end
        ST_HOLD: if (accept) begin
          state   <= ST_BUSY;
          cur_seg <= req_seg;
          cur_wr  <= req_write;
          burst   <= (req_seg == cur_seg) ? burst + BC_W'(1) : BC_W'(1);
        end else begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_on = (state == ST_BUSY) || (state == ST_HOLD);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_cs
    assign cs_n[g] = !(sel_on && (cur_seg == SEG_W'(g)));
  end

  assign oe_n = !((state == ST_BUSY) && !cur_wr);
  assign we_n = !((state == ST_BUSY) && cur_wr);
  assign done = fin;

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!por_n)
    !(!oe_n && !we_n));

  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(~cs_n));

  assert_release_after_burst_R5: assert property (@(posedge clk) disable iff (!por_n)
    (done && burst == BC_W'(BURST_MAX)) |=> ((&cs_n) && !req_ready));

  assert_seq_floor_R6: assert property (@(posedge clk) disable iff (!por_n)
    (accept && use_seq && cfg_we_dev[req_seg]) |-> (wait_val != '0));

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!por_n)
    accept |=> !req_ready);

endmodule

// File: tb/smc_ctrl_test.sv
`timescale 1ns/1ps
module smc_ctrl_test;

  localparam int NUM_SEG = 6;
  localparam int ADDR_W  = 28;

  logic                      clk = 1'b0;
  logic                      por_n = 1'b0;
  logic [1:0]                boot_strap = 2'b11;
  logic                      boot_undef;
  logic [(NUM_SEG-1)*2-1:0]  cfg_width = '0;
  logic [NUM_SEG*3-1:0]      cfg_rand_ws = '0;
  logic [NUM_SEG*2-1:0]      cfg_seq_ws = '0;
  logic [NUM_SEG-1:0]        cfg_page_en = '0;
  logic [NUM_SEG-1:0]        cfg_we_dev = '0;
  logic                      req_valid = 1'b0;
  logic                      req_ready;
  logic [2:0]                req_seg = '0;
  logic [ADDR_W-1:0]         req_addr = '0;
  logic                      req_write = 1'b0;
  logic                      done;
  logic                      ext_ready = 1'b1;
  logic [NUM_SEG-1:0]        cs_n;
  logic                      oe_n;
  logic                      we_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smc_ctrl uut (
    .clk(clk), .por_n(por_n), .boot_strap(boot_strap), .boot_undef(boot_undef),
    .cfg_width(cfg_width), .cfg_rand_ws(cfg_rand_ws), .cfg_seq_ws(cfg_seq_ws),
    .cfg_page_en(cfg_page_en), .cfg_we_dev(cfg_we_dev),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_addr(req_addr), .req_write(req_write), .done(done),
    .ext_ready(ext_ready), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic set_seg(input int s, input int wcode, input int rnd, input int sq,
                         input bit page, input bit wedev);
    if (s > 0) cfg_width[(s-1)*2 +: 2] = 2'(wcode);
    cfg_rand_ws[s*3 +: 3] = 3'(rnd);
    cfg_seq_ws[s*2 +: 2]  = 2'(sq);
    cfg_page_en[s]        = page;
    cfg_we_dev[s]         = wedev;
  endtask

  // Called at a falling edge. exp_rel: 1 release expected before accept,
  // 0 select held, -1 not checked.
  task automatic access(input int s, input int addr, input bit wr, input int rdy_low,
                        input int exp_cyc, input int exp_rel, input string req);
    int cyc;
    bit rel;
    rel = 0;
    req_valid = 1'b1; req_seg = 3'(s); req_addr = ADDR_W'(addr); req_write = wr;
    ext_ready = 1'b1;
    #1;
    forever begin
      if (&cs_n) rel = 1;
      if (req_ready) break;
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    forever begin
      cyc++;
      ext_ready = (cyc > rdy_low);
      #1;
      if (cyc == 1) begin
        chk(cs_n == ~(6'b1 << s), req, "select of target segment", int'(cs_n), int'(~(6'b1 << s)));
        chk(oe_n == wr && we_n == !wr, req, "strobe levels {oe,we}",
            int'({oe_n, we_n}), int'({wr, !wr}));
        chk(!req_ready, "R11", "ready low while busy", int'(req_ready), 0);
      end
      if (done || cyc > 40) break;
      @(negedge clk);
    end
    ext_ready = 1'b1;
    chk(cyc == exp_cyc, req, "access cycle count", cyc, exp_cyc);
    if (exp_rel >= 0) chk(int'(rel) == exp_rel, req, "select release before accept", int'(rel), exp_rel);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    por_n = 1'b0; boot_strap = s;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    boot_strap = ~s;
    #1;
  endtask

  task automatic t_reset();
    do_reset(2'b11);
    chk(cs_n == '1, "R1", "cs_n after reset", int'(cs_n), 63);
    chk(oe_n && we_n, "R1", "strobes after reset", int'({oe_n, we_n}), 3);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    chk(!done, "R1", "done after reset", int'(done), 0);
    chk(boot_undef, "R8", "undef flag for strap 11", int'(boot_undef), 1);
    @(negedge clk);
  endtask

  task automatic t_random();
    set_seg(1, 0, 0, 0, 0, 0);
    set_seg(2, 0, 7, 0, 0, 0);
    access(1, 'h40, 0, 0, 2, 1, "R2");
    settle();
    access(2, 'h80, 1, 0, 9, 1, "R2");
    settle();
  endtask

  task automatic t_page();
    set_seg(1, 2, 3, 2, 1, 0);
    access(1, 'h100, 0, 0, 5, 1, "R3");
    access(1, 'h102, 0, 0, 3, 0, "R3");
    access(1, 'h104, 0, 0, 3, 0, "R3");
    access(1, 'h106, 0, 0, 3, 0, "R3");
    access(1, 'h108, 0, 0, 5, 1, "R5");
    settle();
    access(1, 'h200, 0, 0, 5, 1, "R3");
    access(1, 'h204, 0, 0, 5, 0, "R3");
    settle();
  endtask

  task automatic t_nopage();
    set_seg(2, 0, 1, 0, 0, 0);
    access(2, 'h300, 0, 0, 3, 1, "R4");
    access(2, 'h304, 1, 0, 3, 0, "R4");
    access(2, 'h308, 0, 0, 3, 0, "R4");
    access(2, 'h30C, 0, 0, 3, 0, "R4");
    access(2, 'h310, 0, 0, 3, 1, "R5");
    settle();
  endtask

  task automatic t_wefloor();
    set_seg(3, 0, 0, 0, 1, 1);
    set_seg(4, 0, 0, 0, 1, 0);
    access(3, 'h10, 1, 0, 2, 1, "R6");
    access(3, 'h14, 1, 0, 2, 0, "R6");
    settle();
    access(4, 'h10, 0, 0, 2, 1, "R3");
    access(4, 'h14, 0, 0, 1, 0, "R3");
    settle();
  endtask

  task automatic t_ready();
    set_seg(1, 0, 0, 0, 0, 0);
    set_seg(5, 0, 2, 0, 0, 0);
    access(1, 'h40, 0, 4, 5, 1, "R7");
    settle();
    access(5, 'h40, 1, 2, 4, 1, "R7");
    settle();
  endtask

  task automatic t_switch();
    set_seg(1, 2, 3, 2, 1, 0);
    set_seg(4, 0, 0, 0, 1, 0);
    access(1, 'h500, 0, 0, 5, 1, "R9");
    access(4, 'h504, 0, 0, 2, 0, "R9");
    access(4, 'h508, 0, 0, 1, 0, "R9");
    access(4, 'h50C, 0, 0, 1, 0, "R9");
    access(4, 'h510, 0, 0, 1, 0, "R9");
    access(4, 'h514, 0, 0, 2, 1, "R9");
    settle();
  endtask

  task automatic t_idle_release();
    set_seg(1, 2, 3, 2, 1, 0);
    access(1, 'h600, 0, 0, 5, 1, "R10");
    @(negedge clk); #1;
    chk(cs_n[1] == 1'b0 && req_ready, "R10", "select held one cycle after done",
        int'(cs_n), 61);
    @(negedge clk); #1;
    chk(cs_n == '1, "R10", "select released without request", int'(cs_n), 63);
    access(1, 'h602, 0, 0, 5, 1, "R10");
    settle();
  endtask

  task automatic t_boot();
    set_seg(0, 0, 2, 0, 1, 0);
    do_reset(2'b01);
    chk(!boot_undef, "R8", "undef flag for strap 01", int'(boot_undef), 0);
    access(0, 'h20, 0, 0, 4, 1, "R8");
    access(0, 'h21, 0, 0, 1, 0, "R8");
    settle();
    do_reset(2'b10);
    access(0, 'h20, 0, 0, 4, 1, "R8");
    access(0, 'h22, 0, 0, 1, 0, "R8");
    settle();
    do_reset(2'b00);
    chk(!boot_undef, "R8", "undef flag for strap 00", int'(boot_undef), 0);
    access(0, 'h20, 0, 0, 4, 1, "R8");
    access(0, 'h22, 0, 0, 4, 0, "R8");
    settle();
    do_reset(2'b11);
    chk(boot_undef, "R8", "undef flag held after strap 11", int'(boot_undef), 1);
    access(0, 'h20, 0, 0, 4, 1, "R8");
    access(0, 'h24, 0, 0, 1, 0, "R8");
    settle();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    end_run();
  end

  initial begin
    t_reset();
    t_random();
    t_page();
    t_nopage();
    t_wefloor();
    t_ready();
    t_switch();
    t_idle_release();
    t_boot();
    end_run();
  end

endmodule